// File: doc/BRIEF.md
# Byte-Reversing Load/Store Lane Unit

This unit is the data-side stage between a 32-bit core and a byte-addressed, big-endian data bus. It takes one decoded load or store per cycle and issues one bus request on the next cycle. The request carries the final address, the byte enables and the store data already placed into its lanes. A load stays pending until the bus returns its data. The unit then takes the addressed lanes, zero-extends them and presents them as the value for the destination register.

Register-form instructions can ask for a reversed access through one bit of the instruction word. A reversed access mirrors the sub-word position inside the 32-bit word and byte-swaps the data. On a store the swap is applied before the data reaches the bus. On a load it is applied after the returned data has been extracted.

The unit detects two faults before any bus traffic. One is an unsupported access size, when the trap for it is configured. The other is a misaligned halfword or word, when the alignment trap is on. A faulting request issues no bus access and raises an exception record instead.

Top module: `lsu_lane_rev`

## Requirements
- R1: The size code `req_size` selects 1, 2 or 4 bytes for codes 0, 1 and 2. Lane numbering is big-endian: byte offset k drives `bus_be[3-k]` and data bits [31-8k:24-8k]. A halfword drives `bus_be` 1100 at offset 0 and 0011 at offset 2, and a word drives 1111. `bus_req` is high for exactly the one cycle that follows an accepted request.
- R2: The reverse flag is bit 9 of `req_instr` and applies only when `req_imm_form` is 0. In immediate form the access behaves as a normal access.
- R3: A reversed byte access replaces address bits [1:0] with 3 minus their value and keeps every other address bit.
- R4: A reversed halfword access inverts address bit 1 and keeps every other bit.
- R5: A reversed word access keeps the address unchanged. It reverses all four bytes of the store data and of the load result.
- R6: A reversed halfword swaps the two bytes of the low 16 bits of its source, and source bits 31:16 have no effect. Byte data is never swapped.
- R7: A store drives its (possibly swapped) data in the lanes selected by R1, and every lane that is not enabled reads 0 on `bus_wdata`. `bus_we` is 1 for a store and 0 for a load.
- R8: A load takes the enabled lanes of `bus_rdata`, zero-extends them, and then applies any swap. `ld_valid` is high for the one cycle after `bus_rvalid` and shows the result in `ld_data`, with the register index from `req_instr[25:21]` in `ld_rd`.
- R9: A load to register 0 still issues its bus read. On the response it gives `ld_valid`=1, `ld_wen`=0 and `ld_data`=0, and no swap is applied.
- R10: Size code 3 with both `cfg_exc_en` and `cfg_ill_trap` set raises `exc_code`=1 (illegal) and issues no bus access. In every other case, size code 3 is carried out as a word access.
- R11: When `cfg_align_trap` is set, a halfword with address bit 0 set, or a word with any of address bits [1:0] set, raises `exc_code`=2 (alignment). It reports `exc_rd`, `exc_store` and `exc_size_m1` (size in bytes minus 1) and issues no bus access. The illegal-size check takes priority.
- R12: When no fault applies, `exc_valid` stays 0. With `cfg_align_trap` clear, a misaligned access is issued with the address as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code (0 byte, 1 halfword, 2 word, 3 unsupported) |
| req_imm_form | input | 1 | Instruction is immediate form (reverse flag ignored) |
| req_instr | input | 32 | Instruction word (bit 9 reverse, bits 25:21 register) |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store source register value |
| cfg_exc_en | input | 1 | Exceptions enabled |
| cfg_ill_trap | input | 1 | Trap on unsupported size |
| cfg_align_trap | input | 1 | Trap on misalignment |
| bus_req | output | 1 | Bus access strobe |
| bus_we | output | 1 | Bus write |
| bus_addr | output | 32 | Final bus address |
| bus_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | output | 32 | Store data in lanes |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | 32 | Read data |
| ld_valid | output | 1 | Load result strobe |
| ld_wen | output | 1 | Destination write enable |
| ld_rd | output | 5 | Destination register index |
| ld_data | output | 32 | Load result |
| exc_valid | output | 1 | Exception strobe |
| exc_code | output | 2 | 1 illegal size, 2 alignment |
| exc_rd | output | 5 | Register index of the faulting access |
| exc_store | output | 1 | Faulting access was a store |
| exc_size_m1 | output | 3 | Requested size in bytes minus 1 |

## Verification
The properties assume at most one load in flight. No new request may arrive while a load waits for its data, and `bus_rvalid` is raised only while a read is outstanding and never in the same cycle as a request. The stimulus drives every request and every response on the falling edge. It completes each load's response before it presents the next request, so the timing checks on `bus_req`, `ld_valid` and `exc_valid` hold in every cycle.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } lsu_size_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_ALIGN   = 2'd2
  } lsu_exc_e;
endpackage

// File: rtl/lsu_req_decode.sv
module lsu_req_decode
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int LANE_W  = 2,
  parameter int RD_W    = 5,
  parameter int RD_LSB  = 21,
  parameter int REV_BIT = 9
) (
  input  logic [1:0]         op_size,
  input  logic               imm_form,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               cfg_exc_en,
  input  logic               cfg_ill_trap,
  input  logic               cfg_align_trap,
  output lsu_size_e          eff_size,
  output logic               rev,
  output logic [ADDR_W-1:0]  fin_addr,
  output logic [LANE_W-1:0]  lane_off,
  output logic               illegal,
  output logic               misalign,
  output logic [RD_W-1:0]    rd,
  output logic [2:0]         size_m1
);
  lsu_size_e raw_size;

  always_comb begin
    raw_size = lsu_size_e'(op_size);
    rev      = ~imm_form & instr[REV_BIT];
    illegal  = (raw_size == SZ_WIDE) & cfg_exc_en & cfg_ill_trap;
    eff_size = (raw_size == SZ_WIDE) ? SZ_WORD : raw_size;
    rd       = instr[RD_LSB +: RD_W];
    case (raw_size)
      SZ_BYTE: size_m1 = 3'd0;
      SZ_HALF: size_m1 = 3'd1;
      SZ_WORD: size_m1 = 3'd3;
      default: size_m1 = 3'd7;
    endcase
  end

  // Mirror the sub-word position inside the bus word for reversed accesses.
  always_comb begin
    fin_addr = addr;
    if (rev) begin
      case (eff_size)
        SZ_BYTE: fin_addr[LANE_W-1:0] = ~addr[LANE_W-1:0];
        SZ_HALF: fin_addr[LANE_W-1:1] = ~addr[LANE_W-1:1];
        default: fin_addr = addr;
      endcase
    end
  end

  always_comb begin
    case (eff_size)
      SZ_BYTE: begin
        lane_off = fin_addr[LANE_W-1:0];
        misalign = 1'b0;
      end
      SZ_HALF: begin
        lane_off = {fin_addr[LANE_W-1:1], 1'b0};
        misalign = cfg_align_trap & fin_addr[0];
      end
      default: begin
        lane_off = '0;
        misalign = cfg_align_trap & (|fin_addr[LANE_W-1:0]);
      end
    endcase
    if (illegal) misalign = 1'b0;
  end
endmodule

// File: rtl/lsu_lane_swap.sv
module lsu_lane_swap
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  lsu_size_e         size,
  input  logic              rev,
  output logic [DATA_W-1:0] dout
);
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] word_sw;
  logic [15:0]       half_sw;

  for (genvar g = 0; g < BYTES; g++) begin : g_rev
    assign word_sw[8*g +: 8] = din[DATA_W-8-8*g +: 8];
  end

  assign half_sw = {din[7:0], din[15:8]};

  always_comb begin
    dout = din;
    if (rev) begin
      case (size)
        SZ_HALF: dout = {{(DATA_W-16){1'b0}}, half_sw};
        SZ_WORD: dout = word_sw;
        default: dout = din;
      endcase
    end
  end
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int LANE_W = $clog2(BYTES)
) (
  input  lsu_size_e         size,
  input  logic [LANE_W-1:0] lane_off,
  input  logic [DATA_W-1:0] data,
  output logic [BYTES-1:0]  be,
  output logic [DATA_W-1:0] lanes
);
  logic [LANE_W:0]   nbytes;
  logic [LANE_W:0]   lane_sh;
  logic [DATA_W-1:0] mask;
  logic [BYTES-1:0]  be_base;

  always_comb begin
    case (size)
      SZ_BYTE: begin nbytes = (LANE_W+1)'(1); mask = DATA_W'(8'hFF);   end
      SZ_HALF: begin nbytes = (LANE_W+1)'(2); mask = DATA_W'(16'hFFFF); end
      default: begin nbytes = (LANE_W+1)'(BYTES); mask = '1;           end
    endcase
    lane_sh = (LANE_W+1)'(BYTES) - nbytes - {1'b0, lane_off};
    for (int i = 0; i < BYTES; i++) begin
      be_base[i] = ((LANE_W+1)'(i) < nbytes);
    end
    be    = be_base << lane_sh;
    lanes = (data & mask) << {lane_sh, 3'b000};
  end
endmodule

// File: rtl/lsu_load_unpack.sv
module lsu_load_unpack
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int LANE_W = $clog2(BYTES)
) (
  input  lsu_size_e         size,
  input  logic [LANE_W-1:0] lane_off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] field
);
  logic [LANE_W:0]   nbytes;
  logic [LANE_W:0]   lane_sh;
  logic [DATA_W-1:0] mask;

  always_comb begin
    case (size)
      SZ_BYTE: begin nbytes = (LANE_W+1)'(1); mask = DATA_W'(8'hFF);   end
      SZ_HALF: begin nbytes = (LANE_W+1)'(2); mask = DATA_W'(16'hFFFF); end
      default: begin nbytes = (LANE_W+1)'(BYTES); mask = '1;           end
    endcase
    lane_sh = (LANE_W+1)'(BYTES) - nbytes - {1'b0, lane_off};
    field   = (rdata >> {lane_sh, 3'b000}) & mask;
  end
endmodule

// File: rtl/lsu_lane_rev.sv
module lsu_lane_rev
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int RD_W    = 5,
  parameter int RD_LSB  = 21,
  parameter int REV_BIT = 9,
  localparam int BYTES  = DATA_W / 8,
  localparam int LANE_W = $clog2(BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_store,
  input  logic [1:0]         req_size,
  input  logic               req_imm_form,
  input  logic [INSTR_W-1:0] req_instr,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               cfg_exc_en,
  input  logic               cfg_ill_trap,
  input  logic               cfg_align_trap,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [BYTES-1:0]   bus_be,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rvalid,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               ld_valid,
  output logic               ld_wen,
  output logic [RD_W-1:0]    ld_rd,
  output logic [DATA_W-1:0]  ld_data,
  output logic               exc_valid,
  output logic [1:0]         exc_code,
  output logic [RD_W-1:0]    exc_rd,
  output logic               exc_store,
  output logic [2:0]         exc_size_m1
);
  // Request decode
  lsu_size_e         dec_size;
  logic              dec_rev;
  logic [ADDR_W-1:0] dec_addr;
  logic [LANE_W-1:0] dec_off;
  logic              dec_ill;
  logic              dec_mis;
  logic [RD_W-1:0]   dec_rd;
  logic [2:0]        dec_szm1;

  lsu_req_decode #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .LANE_W(LANE_W),
    .RD_W(RD_W), .RD_LSB(RD_LSB), .REV_BIT(REV_BIT)
  ) u_decode (
    .op_size(req_size), .imm_form(req_imm_form), .instr(req_instr),
    .addr(req_addr), .cfg_exc_en(cfg_exc_en), .cfg_ill_trap(cfg_ill_trap),
    .cfg_align_trap(cfg_align_trap), .eff_size(dec_size), .rev(dec_rev),
    .fin_addr(dec_addr), .lane_off(dec_off), .illegal(dec_ill),
    .misalign(dec_mis), .rd(dec_rd), .size_m1(dec_szm1)
  );

  // Store path: swap, then place into lanes
  logic [DATA_W-1:0] st_swapped;
  logic [DATA_W-1:0] st_lanes;
  logic [BYTES-1:0]  st_be;

  lsu_lane_swap #(.DATA_W(DATA_W)) u_st_swap (
    .din(req_wdata), .size(dec_size), .rev(dec_rev), .dout(st_swapped)
  );

  lsu_store_pack #(.DATA_W(DATA_W)) u_pack (
    .size(dec_size), .lane_off(dec_off), .data(st_swapped),
    .be(st_be), .lanes(st_lanes)
  );

  // Pending load context
  logic              pend_q, pend_d;
  lsu_size_e         pend_size_q;
  logic [LANE_W-1:0] pend_off_q;
  logic              pend_rev_q;
  logic [RD_W-1:0]   pend_rd_q;

  // Load path: extract lanes, then swap
  logic [DATA_W-1:0] ld_field;
  logic [DATA_W-1:0] ld_swapped;

  lsu_load_unpack #(.DATA_W(DATA_W)) u_unpack (
    .size(pend_size_q), .lane_off(pend_off_q), .rdata(bus_rdata), .field(ld_field)
  );

  lsu_lane_swap #(.DATA_W(DATA_W)) u_ld_swap (
    .din(ld_field), .size(pend_size_q), .rev(pend_rev_q), .dout(ld_swapped)
  );

  // Next-state logic
  logic issue;
  logic fault;
  logic ld_fire;
  logic bus_req_d;
  logic exc_valid_d;
  logic ld_valid_d;
  logic ld_hit_rd;
  lsu_exc_e exc_code_d;

  always_comb begin
    fault       = dec_ill | dec_mis;
    issue       = req_valid & ~fault;
    bus_req_d   = issue;
    exc_valid_d = req_valid & fault;
    exc_code_d  = dec_ill ? EXC_ILLEGAL : EXC_ALIGN;
    ld_fire     = bus_rvalid & pend_q;
    ld_valid_d  = ld_fire;
    ld_hit_rd   = (pend_rd_q != '0);
    pend_d      = pend_q;
    if (ld_fire) pend_d = 1'b0;
    if (issue & ~req_store) pend_d = 1'b1;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      exc_valid <= 1'b0;
      ld_valid  <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      bus_req   <= bus_req_d;
      exc_valid <= exc_valid_d;
      ld_valid  <= ld_valid_d;
      pend_q    <= pend_d;
    end
  end

  // Request data registers, enabled by the request strobe
  always_ff @(posedge clk) begin
    if (req_valid) begin
      bus_we      <= req_store;
      bus_addr    <= dec_addr;
      bus_be      <= st_be;
      bus_wdata   <= req_store ? st_lanes : '0;
      exc_code    <= exc_code_d;
      exc_rd      <= dec_rd;
      exc_store   <= req_store;
      exc_size_m1 <= dec_szm1;
    end
  end

  // Load context, enabled when a read is issued
  always_ff @(posedge clk) begin
    if (issue & ~req_store) begin
      pend_size_q <= dec_size;
      pend_off_q  <= dec_off;
      pend_rev_q  <= dec_rev;
      pend_rd_q   <= dec_rd;
    end
  end

  // Load result, enabled by the response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_wen <= 1'b0;
    end else begin
      ld_wen <= ld_fire & ld_hit_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_fire) begin
      ld_rd   <= pend_rd_q;
      ld_data <= ld_hit_rd ? ld_swapped : '0;
    end
  end
endmodule

// File: rtl/lsu_lane_rev_chk.sv
module lsu_lane_rev_chk #(
  parameter int BYTES = 4,
  parameter int RD_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             bus_req,
  input logic             bus_we,
  input logic [BYTES-1:0] bus_be,
  input logic [31:0]      bus_wdata,
  input logic             bus_rvalid,
  input logic             ld_valid,
  input logic             ld_wen,
  input logic [RD_W-1:0]  ld_rd,
  input logic             exc_valid
);
  assert_bus_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $past(req_valid));

  assert_be_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4));

  assert_half_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $countones(bus_be) == 2) |-> (bus_be == 4'b1100 || bus_be == 4'b0011));

  assert_idle_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_be[0]) |-> (bus_wdata[7:0] == 8'h00));

  assert_ld_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(bus_rvalid));

  assert_rd0_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wen |-> (ld_valid && ld_rd != '0));

  assert_fault_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !bus_req);

  assert_exc_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(req_valid));
endmodule

bind lsu_lane_rev lsu_lane_rev_chk #(.BYTES(4), .RD_W(5)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_req(bus_req),
  .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .ld_valid(ld_valid), .ld_wen(ld_wen),
  .ld_rd(ld_rd), .exc_valid(exc_valid)
);

// File: tb/lsu_lane_rev_bench.sv
module lsu_lane_rev_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, req_imm_form;
  logic [1:0]  req_size;
  logic [31:0] req_instr, req_addr, req_wdata;
  logic        cfg_exc_en, cfg_ill_trap, cfg_align_trap;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        ld_valid, ld_wen;
  logic [4:0]  ld_rd;
  logic [31:0] ld_data;
  logic        exc_valid, exc_store;
  logic [1:0]  exc_code;
  logic [4:0]  exc_rd;
  logic [2:0]  exc_size_m1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  lsu_lane_rev u_lsu_lane_rev (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        imm;
    logic        rev;
    logic [31:0] addr;
    logic [31:0] din;
    logic [31:0] eaddr;
    logic [3:0]  ebe;
    logic [31:0] edat;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 32'h10000001, 32'hAABBCCDD, 32'h10000001, 4'b0100, 32'h000000BB, 8'd8}, // R8 byte lane
    '{1'b0, 2'd0, 1'b0, 1'b1, 32'h10000001, 32'hAABBCCDD, 32'h10000002, 4'b0010, 32'h000000CC, 8'd3}, // R3 mirror, R6 no swap
    '{1'b0, 2'd0, 1'b1, 1'b1, 32'h10000001, 32'hAABBCCDD, 32'h10000001, 4'b0100, 32'h000000BB, 8'd2}, // R2 imm form
    '{1'b0, 2'd1, 1'b0, 1'b0, 32'h20000002, 32'h11223344, 32'h20000002, 4'b0011, 32'h00003344, 8'd1}, // R1 half lanes
    '{1'b0, 2'd1, 1'b0, 1'b1, 32'h20000002, 32'h11223344, 32'h20000000, 4'b1100, 32'h00002211, 8'd4}, // R4 half mirror
    '{1'b0, 2'd2, 1'b0, 1'b1, 32'h30000004, 32'h11223344, 32'h30000004, 4'b1111, 32'h44332211, 8'd5}, // R5 word load
    '{1'b0, 2'd2, 1'b0, 1'b0, 32'h30000004, 32'h11223344, 32'h30000004, 4'b1111, 32'h11223344, 8'd8}, // R8 word
    '{1'b1, 2'd0, 1'b0, 1'b0, 32'h40000003, 32'h123456A5, 32'h40000003, 4'b0001, 32'h000000A5, 8'd7}, // R7 byte store
    '{1'b1, 2'd0, 1'b0, 1'b1, 32'h40000003, 32'h123456A5, 32'h40000000, 4'b1000, 32'hA5000000, 8'd3}, // R3 store mirror
    '{1'b1, 2'd1, 1'b0, 1'b1, 32'h40000000, 32'h9999BEEF, 32'h40000002, 4'b0011, 32'h0000EFBE, 8'd6}, // R6 upper ignored
    '{1'b1, 2'd1, 1'b0, 1'b0, 32'h40000000, 32'h9999BEEF, 32'h40000000, 4'b1100, 32'hBEEF0000, 8'd7}, // R7 half store
    '{1'b1, 2'd2, 1'b0, 1'b1, 32'h50000008, 32'h01020304, 32'h50000008, 4'b1111, 32'h04030201, 8'd5}, // R5 word store
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h50000008, 32'h01020304, 32'h50000008, 4'b1111, 32'h01020304, 8'd7}, // R7 word store
    '{1'b0, 2'd0, 1'b0, 1'b1, 32'h60000000, 32'hAABBCCDD, 32'h60000003, 4'b0001, 32'h000000DD, 8'd3}  // R3 offset 0
  };

  task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic send(input logic st, input logic [1:0] sz, input logic imm, input logic rev,
                      input logic [4:0] rd, input logic [31:0] addr, input logic [31:0] wd);
    @(negedge clk);
    req_valid    = 1'b1;
    req_store    = st;
    req_size     = sz;
    req_imm_form = imm;
    req_instr    = (32'(rd) << 21) | (32'(rev) << 9);
    req_addr     = addr;
    req_wdata    = wd;
    @(negedge clk);
    req_valid    = 1'b0;
  endtask

  task automatic respond(input logic [31:0] d);
    bus_rvalid = 1'b1;
    bus_rdata  = d;
    @(negedge clk);
    bus_rvalid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0; req_imm_form = 1'b0;
    req_instr = '0; req_addr = '0; req_wdata = '0;
    cfg_exc_en = 1'b1; cfg_ill_trap = 1'b1; cfg_align_trap = 1'b1;
    bus_rvalid = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    // Reset state (R1 idle bus, R12 no exception)
    chk(1, "reset bus_req", 32'(bus_req), 0);
    chk(8, "reset ld_valid", 32'(ld_valid), 0);
    chk(12, "reset exc_valid", 32'(exc_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].st, VEC[i].sz, VEC[i].imm, VEC[i].rev, 5'd7, VEC[i].addr, VEC[i].din);
      chk(1, "bus_req", 32'(bus_req), 1);
      chk(7, "bus_we", 32'(bus_we), 32'(VEC[i].st));
      chk(int'(VEC[i].rq), "bus_addr", bus_addr, VEC[i].eaddr);
      chk(int'(VEC[i].rq), "bus_be", 32'(bus_be), 32'(VEC[i].ebe));
      chk(12, "exc_valid", 32'(exc_valid), 0);
      if (VEC[i].st) begin
        chk(int'(VEC[i].rq), "bus_wdata", bus_wdata, VEC[i].edat);
      end else begin
        respond(VEC[i].din);
        chk(8, "ld_valid", 32'(ld_valid), 1);
        chk(8, "ld_rd", 32'(ld_rd), 7);
        chk(8, "ld_wen", 32'(ld_wen), 1);
        chk(int'(VEC[i].rq), "ld_data", ld_data, VEC[i].edat);
      end
      @(negedge clk);
      chk(1, "bus_req drops", 32'(bus_req), 0);
    end

    // R9: load to register 0
    send(1'b0, 2'd2, 1'b0, 1'b1, 5'd0, 32'h70000000, 32'h0);
    chk(9, "rd0 bus_req", 32'(bus_req), 1);
    respond(32'hDEADBEEF);
    chk(9, "rd0 ld_valid", 32'(ld_valid), 1);
    chk(9, "rd0 ld_wen", 32'(ld_wen), 0);
    chk(9, "rd0 ld_data", ld_data, 32'h0);

    // R10: unsupported size with trap
    send(1'b0, 2'd3, 1'b0, 1'b0, 5'd4, 32'h70000010, 32'h0);
    chk(10, "ill exc_valid", 32'(exc_valid), 1);
    chk(10, "ill exc_code", 32'(exc_code), 1);
    chk(10, "ill bus_req", 32'(bus_req), 0);

    // R10: trap option off gives a word access
    cfg_ill_trap = 1'b0;
    send(1'b1, 2'd3, 1'b0, 1'b0, 5'd4, 32'h70000010, 32'hCAFEF00D);
    chk(10, "wide bus_req", 32'(bus_req), 1);
    chk(10, "wide bus_be", 32'(bus_be), 32'hF);
    chk(10, "wide exc_valid", 32'(exc_valid), 0);
    chk(10, "wide bus_wdata", bus_wdata, 32'hCAFEF00D);
    // R10: exceptions disabled also gives a word access
    cfg_ill_trap = 1'b1; cfg_exc_en = 1'b0;
    send(1'b1, 2'd3, 1'b0, 1'b0, 5'd4, 32'h70000010, 32'hCAFEF00D);
    chk(10, "exc off bus_req", 32'(bus_req), 1);
    chk(10, "exc off exc_valid", 32'(exc_valid), 0);
    cfg_exc_en = 1'b1;

    // R11: misaligned halfword store
    send(1'b1, 2'd1, 1'b0, 1'b0, 5'd7, 32'h80000001, 32'h1234);
    chk(11, "half exc_valid", 32'(exc_valid), 1);
    chk(11, "half exc_code", 32'(exc_code), 2);
    chk(11, "half exc_rd", 32'(exc_rd), 7);
    chk(11, "half exc_store", 32'(exc_store), 1);
    chk(11, "half exc_size_m1", 32'(exc_size_m1), 1);
    chk(11, "half bus_req", 32'(bus_req), 0);
    // R11: misaligned word load
    send(1'b0, 2'd2, 1'b0, 1'b0, 5'd9, 32'h80000002, 32'h0);
    chk(11, "word exc_code", 32'(exc_code), 2);
    chk(11, "word exc_store", 32'(exc_store), 0);
    chk(11, "word exc_size_m1", 32'(exc_size_m1), 3);
    chk(11, "word exc_rd", 32'(exc_rd), 9);
    chk(11, "word bus_req", 32'(bus_req), 0);

    // R12: alignment trap off, misaligned access issued as given
    cfg_align_trap = 1'b0;
    send(1'b0, 2'd2, 1'b0, 1'b0, 5'd3, 32'h80000002, 32'h0);
    chk(12, "noalign bus_req", 32'(bus_req), 1);
    chk(12, "noalign exc_valid", 32'(exc_valid), 0);
    chk(12, "noalign bus_addr", bus_addr, 32'h80000002);
    chk(12, "noalign bus_be", 32'(bus_be), 32'hF);
    respond(32'h55667788);
    chk(12, "noalign ld_data", ld_data, 32'h55667788);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule